// File: doc/BRIEF.md
# Round-Robin Sense Channel Sampler and Averager

This block paces a shared 8-bit converter across two or four current-sense channels. It selects one channel on the analog multiplexer, asks for a single conversion, waits for the converter's done handshake, and then moves to the next channel in a fixed rotation. A slot divider spaces the conversions so that each channel is converted once per millisecond at the default clock.

Every sample goes two ways. It is added into that channel's own accumulator, which keeps counting across the interleaved scans until it has gathered a power-of-two number of samples chosen by a 3-bit averaging code. It is also forwarded at once, unaveraged and tagged with its channel number, to the downstream overcurrent comparator. When a channel's accumulation completes, the average (sum shifted right by the code) replaces that channel's published result byte. Unused result slots of a two-channel build read zero.

The sequencer is a three-state machine. `S_PACE` waits out the slot time and moves to `S_LAUNCH` on the slot tick. `S_LAUNCH` raises the conversion request for one cycle and always moves on to `S_CONVERT`. `S_CONVERT` holds the channel select until the done strobe arrives and then returns to `S_PACE` with the next channel selected.

Top module: `rr_sense_sampler`

## Requirements
- R1: Channels are converted in the order 0, 1, …, NUM_CH-1, 0, … without skipping. `mux_sel` changes only on the edge that accepts a done strobe and stays constant throughout a conversion.
- R2: `conv_start` is high for exactly one cycle per conversion. No new request is made until `conv_done` has been seen for the previous one.
- R3: For averaging code c (0 to 7), a channel's result is published after 2^c of its own samples and equals floor(sum of those samples / 2^c). Code 000 gives 1 sample and code 111 gives 128.
- R4: After reset all result bytes are 00h, `conv_start` and `raw_valid` are low and channel 0 is selected. The stored averaging code is 100 (16 samples), so an input code of 100 does not trigger a restart.
- R5: A result byte keeps its previous value until that channel's next average completes. Reads in between return the old average.
- R6: One cycle after a `conv_done` is accepted, `raw_valid` pulses for one cycle with `raw_data` equal to the raw sample and `raw_chan` equal to the channel it was taken on.
- R7: Any change of `avg_code` discards every channel's partial accumulation, so counting restarts from zero under the new code. Published results are not changed by it.
- R8: In a NUM_CH=2 build, `mux_sel` never exceeds 1 and result bytes 2 and 3 (`result_bus[31:16]`) always read 00h.
- R9: Each channel slot lasts SLOT_CYC = CLK_KHZ/NUM_CH cycles. The cycle in which `conv_start` is high comes exactly SLOT_CYC cycles after the cycle in which the previous `raw_valid` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| avg_code | input | 3 | Averaging depth code; depth = 2^code samples |
| conv_done | input | 1 | Converter done strobe, accepted while converting |
| conv_data | input | 8 | Converted sample, valid with `conv_done` |
| mux_sel | output | 2 | Channel currently routed to the converter |
| conv_start | output | 1 | One-cycle conversion request |
| result_bus | output | 32 | Published averages, channel n in bits [8n+7:8n] |
| raw_valid | output | 1 | Raw sample strobe toward the overcurrent detector |
| raw_chan | output | 2 | Channel of the forwarded raw sample |
| raw_data | output | 8 | Forwarded raw sample |

## Verification
A wrong accumulator or sample count stays hidden until that channel's 2^c-th sample, then shows as a wrong result byte. The bench therefore compares all four result bytes after every conversion over two full averaging windows per channel, for each of the eight codes. A bad channel pointer or a bad state transition shows within one slot as a wrong `mux_sel` at the request or a mismatched `raw_chan`. A stale accumulator left over after a code change shows at the first average completed under the new code.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
    localparam int SMP_W  = 8;
    localparam int CODE_W = 3;
    localparam int CNT_W  = 7;
    localparam int ACC_W  = SMP_W + CNT_W;
    localparam int MAX_CH = 4;
    localparam int SEL_W  = 2;

    typedef enum logic [1:0] {
        S_PACE    = 2'd0,
        S_LAUNCH  = 2'd1,
        S_CONVERT = 2'd2
    } seq_state_t;

    localparam logic [CODE_W-1:0] CODE_RESET = 3'b100;
endpackage

// File: rtl/rrs_pacer.sv
module rrs_pacer #(
    parameter int SLOT_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int W = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;
    localparam logic [W-1:0] LAST = W'(SLOT_CYC - 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt_q <= '0;
        else if (cnt_q != LAST)
            cnt_q <= cnt_q + 1'b1;
    end

    assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/rrs_chan_avg.sv
module rrs_chan_avg
    import rrs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              smp_valid,
    input  logic [SMP_W-1:0]  smp,
    input  logic [CODE_W-1:0] code,
    output logic [SMP_W-1:0]  avg
);
    logic [ACC_W-1:0] acc_q;
    logic [CNT_W-1:0] cnt_q;
    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] shifted;
    logic [CNT_W-1:0] last_cnt;
    logic             window_full;

    always_comb begin
        sum         = acc_q + ACC_W'(smp);
        shifted     = sum >> code;
        last_cnt    = CNT_W'((8'd1 << code) - 8'd1);
        window_full = (cnt_q == last_cnt);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            cnt_q <= '0;
            avg   <= '0;
        end else if (restart) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (smp_valid) begin
            if (window_full) begin
                avg   <= shifted[SMP_W-1:0];
                acc_q <= '0;
                cnt_q <= '0;
            end else begin
                acc_q <= sum;
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rr_sense_sampler.sv
module rr_sense_sampler
    import rrs_pkg::*;
#(
    parameter int NUM_CH  = 4,
    parameter int CLK_KHZ = 100000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CODE_W-1:0]       avg_code,
    input  logic                    conv_done,
    input  logic [SMP_W-1:0]        conv_data,
    output logic [SEL_W-1:0]        mux_sel,
    output logic                    conv_start,
    output logic [MAX_CH*SMP_W-1:0] result_bus,
    output logic                    raw_valid,
    output logic [SEL_W-1:0]        raw_chan,
    output logic [SMP_W-1:0]        raw_data
);
    localparam int SLOT_CYC = (CLK_KHZ / NUM_CH > 0) ? CLK_KHZ / NUM_CH : 1;
    localparam logic [SEL_W-1:0] LAST_CH = SEL_W'(NUM_CH - 1);

    seq_state_t        state_q, state_d;
    logic [SEL_W-1:0]  ch_q;
    logic [CODE_W-1:0] code_q;
    logic              tick;
    logic              accept;
    logic              restart;

    rrs_pacer #(.SLOT_CYC(SLOT_CYC)) u_pacer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q == S_PACE),
        .tick  (tick)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_PACE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_PACE:    if (tick) state_d = S_LAUNCH;
            S_LAUNCH:  state_d = S_CONVERT;
            S_CONVERT: if (conv_done) state_d = S_PACE;
            default:   state_d = S_PACE;
        endcase
    end

    // outputs of the sequencer
    always_comb begin
        conv_start = (state_q == S_LAUNCH);
        accept     = (state_q == S_CONVERT) && conv_done;
        mux_sel    = ch_q;
        restart    = (avg_code != code_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_q      <= '0;
            code_q    <= CODE_RESET;
            raw_valid <= 1'b0;
            raw_chan  <= '0;
            raw_data  <= '0;
        end else begin
            code_q    <= avg_code;
            raw_valid <= accept;
            if (accept) begin
                raw_chan <= ch_q;
                raw_data <= conv_data;
                ch_q     <= (ch_q == LAST_CH) ? '0 : ch_q + 1'b1;
            end
        end
    end

    for (genvar c = 0; c < MAX_CH; c++) begin : g_chan
        if (c < NUM_CH) begin : g_live
            rrs_chan_avg u_avg (
                .clk       (clk),
                .rst_n     (rst_n),
                .restart   (restart),
                .smp_valid (accept && (ch_q == SEL_W'(c))),
                .smp       (conv_data),
                .code      (code_q),
                .avg       (result_bus[c*SMP_W +: SMP_W])
            );
        end else begin : g_absent
            assign result_bus[c*SMP_W +: SMP_W] = '0;
        end
    end
endmodule

// File: rtl/rrs_checker.sv
module rrs_checker #(
    parameter int NUM_CH = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        conv_done,
    input logic [7:0]  conv_data,
    input logic [1:0]  mux_sel,
    input logic        conv_start,
    input logic [31:0] result_bus,
    input logic        raw_valid,
    input logic [1:0]  raw_chan,
    input logic [7:0]  raw_data
);
    localparam logic [1:0] LAST = 2'(NUM_CH - 1);

    assert_chan_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mux_sel <= LAST);

    assert_chan_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mux_sel != $past(mux_sel)) |->
            ($past(conv_done) && mux_sel == (($past(mux_sel) == LAST) ? 2'd0 : $past(mux_sel) + 2'd1)));

    assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    assert_result_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !raw_valid |-> $stable(result_bus));

    assert_raw_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        raw_valid |-> ($past(conv_done) && raw_chan == $past(mux_sel) && raw_data == $past(conv_data)));

    assert_raw_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        raw_valid |=> !raw_valid);
endmodule

bind rr_sense_sampler rrs_checker #(.NUM_CH(NUM_CH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_done  (conv_done),
    .conv_data  (conv_data),
    .mux_sel    (mux_sel),
    .conv_start (conv_start),
    .result_bus (result_bus),
    .raw_valid  (raw_valid),
    .raw_chan   (raw_chan),
    .raw_data   (raw_data)
);

// File: tb/sim_rr_sense_sampler.sv
`timescale 1ns/1ps
module sim_rr_sense_sampler;
    localparam int SLOT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  avg_code = 3'b100;
    logic        conv_done = 1'b0;
    logic [7:0]  conv_data = 8'h00;
    logic [1:0]  mux_sel;
    logic        conv_start;
    logic [31:0] result_bus;
    logic        raw_valid;
    logic [1:0]  raw_chan;
    logic [7:0]  raw_data;

    logic        done1 = 1'b0;
    logic [1:0]  mux1;
    logic        start1;
    logic [31:0] res1;
    logic        rv1;
    logic [1:0]  rc1;
    logic [7:0]  rd1;
    logic        mux1_bad = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    int exp_acc [4];
    int exp_cnt [4];
    int exp_res [4];
    int exp_ch  = 0;
    int k       = 0;
    int cur_code = 4;
    bit gap_ok  = 0;

    always #2.5 clk = ~clk;

    rr_sense_sampler #(.NUM_CH(4), .CLK_KHZ(16)) u0 (
        .clk(clk), .rst_n(rst_n), .avg_code(avg_code),
        .conv_done(conv_done), .conv_data(conv_data),
        .mux_sel(mux_sel), .conv_start(conv_start), .result_bus(result_bus),
        .raw_valid(raw_valid), .raw_chan(raw_chan), .raw_data(raw_data)
    );

    rr_sense_sampler #(.NUM_CH(2), .CLK_KHZ(6)) u1 (
        .clk(clk), .rst_n(rst_n), .avg_code(3'b001),
        .conv_done(done1), .conv_data(8'hFF),
        .mux_sel(mux1), .conv_start(start1), .result_bus(res1),
        .raw_valid(rv1), .raw_chan(rc1), .raw_data(rd1)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_results(input string req);
        for (int c = 0; c < 4; c++)
            check(result_bus[c*8 +: 8] == 8'(exp_res[c]), req, result_bus[c*8 +: 8], exp_res[c]);
    endtask

    task automatic set_code(input int c);
        avg_code = 3'(c);
        cur_code = c;
        for (int i = 0; i < 4; i++) begin exp_acc[i] = 0; exp_cnt[i] = 0; end
        gap_ok = 0;
    endtask

    // one conversion: wait for request, answer, check strobe and results
    task automatic do_conv();
        int gap = 0;
        int lat;
        logic [7:0] d;
        while (!conv_start) begin @(negedge clk); gap++; end
        if (gap_ok) check(gap == SLOT, "R9 slot spacing", gap, SLOT);
        check(mux_sel == 2'(exp_ch), "R1 channel order", mux_sel, exp_ch);
        lat = 1 + (k % 3);
        d = 8'((exp_ch * 53 + k * 29 + cur_code * 7 + (k / 5) * 11));
        repeat (lat) begin
            @(negedge clk);
            check(!conv_start, "R2 single request", conv_start, 0);
            check(mux_sel == 2'(exp_ch), "R1 select held", mux_sel, exp_ch);
        end
        conv_done = 1'b1;
        conv_data = d;
        @(negedge clk);
        conv_done = 1'b0;
        exp_acc[exp_ch] += d;
        exp_cnt[exp_ch] += 1;
        if (exp_cnt[exp_ch] == (1 << cur_code)) begin
            exp_res[exp_ch] = exp_acc[exp_ch] >> cur_code;
            exp_acc[exp_ch] = 0;
            exp_cnt[exp_ch] = 0;
        end
        check(raw_valid == 1'b1, "R6 raw strobe", raw_valid, 1);
        check(raw_chan == 2'(exp_ch) && raw_data == d, "R6 raw content", {raw_chan, raw_data}, {exp_ch[1:0], d});
        check_results("R3 R5 averaged results");
        exp_ch = (exp_ch + 1) % 4;
        k++;
        gap_ok = 1;
    endtask

    // converter model for the two-channel build
    initial begin
        forever begin
            @(negedge clk);
            if (start1) begin
                @(negedge clk); done1 = 1'b1;
                @(negedge clk); done1 = 1'b0;
            end
        end
    end

    always @(negedge clk) if (rst_n && mux1 > 2'd1) mux1_bad = 1'b1;

    initial begin
        for (int i = 0; i < 4; i++) begin exp_acc[i] = 0; exp_cnt[i] = 0; exp_res[i] = 0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R4 reset state
        check(result_bus == 32'h0, "R4 reset results", result_bus, 0);
        check(!conv_start && !raw_valid, "R4 reset strobes", {conv_start, raw_valid}, 0);
        check(mux_sel == 2'd0, "R4 reset channel", mux_sel, 0);
        // R4: code 100 matches the reset code, so accumulation is not restarted
        for (int n = 0; n < 64; n++) do_conv();
        // R3 sweep over every code, two full windows per channel
        for (int c = 0; c < 8; c++) begin
            set_code(c);
            for (int n = 0; n < (1 << c) * 8; n++) do_conv();
        end
        // R7 restart in the middle of a window
        set_code(3);
        for (int n = 0; n < 13; n++) do_conv();
        set_code(2);
        @(negedge clk);
        @(negedge clk);
        check_results("R7 results kept on code change");
        for (int n = 0; n < 32; n++) do_conv();
        // R8 two-channel build
        check(res1[31:16] == 16'h0, "R8 absent slots zero", res1[31:16], 0);
        check(res1[15:0] == 16'hFFFF, "R8 live slots averaged", res1[15:0], 16'hFFFF);
        check(!mux1_bad, "R8 select range", mux1_bad, 0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule